// File: doc/BRIEF.md
# I2C Register-Pair Target

This block is a target on a two-wire I2C bus. It gives a controller access to a small file of 16-bit registers. Each register takes two consecutive byte addresses: the even address holds the high byte and the odd address holds the low byte. A fast system clock samples the bus lines, so the block works at any bus rate up to 400 kHz without any mode setting. The block finds START, repeated START and STOP conditions, compares the 7-bit device address, and takes the first byte of a write as a byte pointer. After that it moves data in either direction, and the pointer advances by one after each byte. The block pulls SDA low through a single open-drain enable.

Writes are guarded. A register changes only when both its high byte and its low byte have arrived in order and their acknowledge clocks have completed. The following are dropped without any notice on the bus:
- a lone high byte cut off by STOP or by a repeated START,
- a low byte that has no high byte before it,
- any byte past the last byte address,
- writes to registers that a parameter marks read-only.

A read of a byte address past the end returns 0xFF.

Top module: `i2c_regpair_target`

## Requirements
- R1: After reset, SDA is released (sda_oe = 0), and every register reads back as 0x0000.
- R2: The target acknowledges only the byte that carries its own 7-bit address (default 0x36, followed by R/W). On any other address it gives no acknowledge on any byte and keeps SDA released until the next START, so the registers stay unchanged.
- R3: A write of a high byte at an even pointer followed by a low byte stores both bytes in that register. A later read returns the high byte first.
- R4: The byte pointer advances after every data byte, in both writes and reads. A write or read of several bytes therefore covers consecutive registers.
- R5: A high byte with no low byte after it, because the write ended with STOP or a repeated START, changes nothing.
- R6: A write that starts at an odd pointer drops its first byte. The pairs that follow are stored normally.
- R7: Data aimed past byte address 0x4F is dropped, and a read of any byte address past 0x4F returns 0xFF.
- R8: Registers marked in the read-only mask (by default registers 1 and 4, byte addresses 0x02-0x03 and 0x08-0x09) ignore writes and keep their value.
- R9: When the controller answers a read byte with NACK, the target releases SDA after that acknowledge clock and drives no more bits. Further clocks read all ones.
- R10: The target changes its SDA drive only while SCL is low.
- R11: A read works as a write portion that sets the pointer, then a repeated START with R/W = 1, which the target acknowledges. The data starts at the pointer that was set.
- R12: During a matched write the target acknowledges every byte, including bytes that it drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; must run many times faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | When 1, the pad pulls SDA low; when 0, SDA is released |

## Verification
The hardest case to reach is a read-only register or an out-of-range byte that still gets its acknowledge. Nothing shows at the pins when such a byte is dropped. The stimulus therefore writes these bytes inside longer writes that also carry valid pairs. It then reads the same range back through a repeated START and compares the bytes with a model kept by the bench. Pending high bytes are cut off by both STOP and repeated START. A write that starts at an odd pointer is used to show that a low byte alone is never stored.

// File: rtl/i2c_regpair_target.sv
module i2c_regpair_target #(
  parameter logic [6:0] DEV_ADDR = 7'h36,
  parameter int NUM_REGS = 40,
  parameter logic [NUM_REGS-1:0] RO_MASK = 40'h12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int IW = $clog2(NUM_REGS);
  localparam logic [7:0] TOP_ADDR = 8'(2 * NUM_REGS - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_DEV_ACK, S_MAD, S_MAD_ACK, S_WR, S_WR_ACK, S_RD, S_RD_ACK
  } st_t;

  logic [2:0] scl_q, sda_q;
  st_t        st;
  logic [3:0] cnt;
  logic [7:0] sh, tx, ptr, hold;
  logic       rw, hold_v, nack;
  logic       wr_en;
  logic [IW-1:0] wr_idx;
  logic [15:0]   wr_data;
  logic [15:0]   regs_q [NUM_REGS];
  logic [7:0]    rd_byte;

  wire scl_now  = scl_q[1];
  wire scl_old  = scl_q[2];
  wire sda_now  = sda_q[1];
  wire sda_old  = sda_q[2];
  wire scl_rise = scl_now & ~scl_old;
  wire scl_fall = ~scl_now & scl_old;
  wire start_c  = scl_now & scl_old & sda_old & ~sda_now;
  wire stop_c   = scl_now & scl_old & ~sda_old & sda_now;
  wire in_range = (ptr <= TOP_ADDR);
  wire in_idle  = (st == S_IDLE);
  wire [IW-1:0] rd_idx = ptr[IW:1];
  wire [7:0] ptr_inc = (ptr == 8'hFF) ? ptr : ptr + 8'd1;

  always_comb begin
    if (!in_range) rd_byte = 8'hFF;
    else if (ptr[0]) rd_byte = regs_q[rd_idx][7:0];
    else rd_byte = regs_q[rd_idx][15:8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      sh      <= '0;
      tx      <= '0;
      ptr     <= '0;
      hold    <= '0;
      hold_v  <= 1'b0;
      rw      <= 1'b0;
      nack    <= 1'b0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_c) begin
        st     <= S_DEV;
        cnt    <= '0;
        sda_oe <= 1'b0;
        hold_v <= 1'b0;
      end else if (stop_c) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
        hold_v <= 1'b0;
      end else begin
        unique case (st)
          S_DEV, S_MAD, S_WR: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_now};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              if (st == S_DEV) begin
                if (sh[7:1] == DEV_ADDR) begin
                  rw     <= sh[0];
                  sda_oe <= 1'b1;
                  st     <= S_DEV_ACK;
                end else begin
                  st <= S_IDLE;
                end
              end else if (st == S_MAD) begin
                ptr    <= sh;
                sda_oe <= 1'b1;
                st     <= S_MAD_ACK;
              end else begin
                sda_oe <= 1'b1;
                st     <= S_WR_ACK;
              end
            end
          end
          S_DEV_ACK: if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              st     <= S_RD;
              tx     <= rd_byte;
              sda_oe <= ~rd_byte[7];
            end else begin
              st     <= S_MAD;
              sda_oe <= 1'b0;
            end
          end
          S_MAD_ACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            st     <= S_WR;
          end
          S_WR_ACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            st     <= S_WR;
            ptr    <= ptr_inc;
            if (in_range && !ptr[0]) begin
              hold   <= sh;
              hold_v <= 1'b1;
            end else begin
              hold_v <= 1'b0;
              if (in_range && hold_v && !RO_MASK[rd_idx]) begin
                wr_en   <= 1'b1;
                wr_idx  <= rd_idx;
                wr_data <= {hold, sh};
              end
            end
          end
          S_RD: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt != 4'd0) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
                st     <= S_RD_ACK;
                ptr    <= ptr_inc;
              end else begin
                tx     <= {tx[6:0], 1'b0};
                sda_oe <= ~tx[6];
              end
            end
          end
          S_RD_ACK: begin
            if (scl_rise) begin
              nack <= sda_now;
            end else if (scl_fall) begin
              cnt <= '0;
              if (nack) begin
                st <= S_IDLE;
              end else begin
                st     <= S_RD;
                tx     <= rd_byte;
                sda_oe <= ~rd_byte[7];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
    end else if (wr_en) begin
      regs_q[wr_idx] <= wr_data;
    end
  end
endmodule

// File: rtl/i2c_regpair_target_chk.sv
module i2c_regpair_target_chk #(
  parameter int NUM_REGS = 40,
  parameter logic [NUM_REGS-1:0] RO_MASK = 40'h12,
  localparam int IW = $clog2(NUM_REGS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          sda_oe,
  input logic          idle,
  input logic          wr_en,
  input logic [IW-1:0] wr_idx
);
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s)); // R10
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !sda_oe); // R2
  AST_RO_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !RO_MASK[wr_idx]); // R8
  AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_idx) < NUM_REGS)); // R7
endmodule

bind i2c_regpair_target i2c_regpair_target_chk #(
  .NUM_REGS(NUM_REGS), .RO_MASK(RO_MASK)
) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_now), .sda_oe(sda_oe),
  .idle(in_idle), .wr_en(wr_en), .wr_idx(wr_idx)
);

// File: tb/i2c_regpair_target_tb_top.sv
module i2c_regpair_target_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int QTR = 20 * CLK_PERIOD;
  localparam logic [6:0] DEV = 7'h36;
  localparam logic [39:0] RO = 40'h12;

  logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe;
  wire sda_bus = m_sda & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_regpair_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe)
  );

  int n_run = 0, n_fail = 0, oe_viol = 0;
  logic [15:0] mdl [40];
  logic [7:0] wb [8];

  typedef struct { logic [7:0] v; string tag; } item_t;
  item_t exp_q[$];
  logic [7:0] got_q[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [7:0] a);
    if (a > 8'h4F) return 8'hFF;
    return a[0] ? mdl[a[6:1]][7:0] : mdl[a[6:1]][15:8];
  endfunction

  // R10: drive change while controller holds SCL high
  always @(sda_oe) if (rst_n && m_scl) oe_viol++;

  initial forever begin
    @(negedge clk);
    while (got_q.size() > 0 && exp_q.size() > 0) begin
      automatic logic [7:0] g = got_q.pop_front();
      automatic item_t e = exp_q.pop_front();
      check(g == e.v, e.tag, 32'(g), 32'(e.v));
    end
  end

  task automatic i2c_start();
    m_sda = 1'b1; #QTR; m_scl = 1'b1; #QTR; m_sda = 1'b0; #QTR; m_scl = 1'b0; #QTR;
  endtask
  task automatic i2c_stop();
    m_sda = 1'b0; #QTR; m_scl = 1'b1; #QTR; m_sda = 1'b1; #QTR;
  endtask
  task automatic send_bit(input logic b);
    m_sda = b; #QTR; m_scl = 1'b1; #QTR; #QTR; m_scl = 1'b0; #QTR;
  endtask
  task automatic recv_bit(output logic b);
    m_sda = 1'b1; #QTR; m_scl = 1'b1; #QTR; b = sda_bus; #QTR; m_scl = 1'b0; #QTR;
  endtask
  task automatic write_byte(input logic [7:0] d, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = !b;
  endtask
  task automatic read_byte(output logic [7:0] d, input logic nak);
    logic b;
    d = '0;
    for (int i = 0; i < 8; i++) begin recv_bit(b); d = {d[6:0], b}; end
    send_bit(nak);
  endtask

  task automatic write_tx(input logic [7:0] maddr, input int n, input bit end_stop, input string tag);
    bit a;
    logic [7:0] p = maddr;
    logic [7:0] pend = '0;
    bit pv = 0;
    i2c_start();
    write_byte({DEV, 1'b0}, a); check(a, {tag, " dev ack R2"}, 32'(a), 1);
    write_byte(maddr, a); check(a, {tag, " ptr ack"}, 32'(a), 1);
    for (int i = 0; i < n; i++) begin
      write_byte(wb[i], a);
      check(a, {tag, " R12 data ack"}, 32'(a), 1);
      if (p <= 8'h4F && !p[0]) begin pend = wb[i]; pv = 1; end
      else begin
        if (p <= 8'h4F && pv && !RO[p[6:1]]) mdl[p[6:1]] = {pend, wb[i]};
        pv = 0;
      end
      if (p != 8'hFF) p++;
    end
    if (end_stop) i2c_stop();
  endtask

  task automatic read_tx(input logic [7:0] maddr, input int n, input string tag);
    bit a;
    logic b;
    logic [7:0] d;
    logic [7:0] p = maddr;
    i2c_start();
    write_byte({DEV, 1'b0}, a); check(a, {tag, " dev ack"}, 32'(a), 1);
    write_byte(maddr, a); check(a, {tag, " ptr ack"}, 32'(a), 1);
    i2c_start();
    write_byte({DEV, 1'b1}, a); check(a, {tag, " R11 read ack"}, 32'(a), 1);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back('{exp_byte(p), tag});
      read_byte(d, (i == n - 1));
      got_q.push_back(d);
      if (p != 8'hFF) p++;
    end
    check(sda_oe == 1'b0, {tag, " R9 released after NACK"}, 32'(sda_oe), 0);
    d = '0;
    for (int i = 0; i < 8; i++) begin recv_bit(b); d = {d[6:0], b}; end
    check(d == 8'hFF, {tag, " R9 no bits after NACK"}, 32'(d), 32'hFF);
    i2c_stop();
  endtask

  initial begin
    #(190000 * CLK_PERIOD);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    bit a;
    for (int i = 0; i < 40; i++) mdl[i] = '0;
    #(5 * CLK_PERIOD); rst_n = 1'b1; #(5 * CLK_PERIOD);
    check(sda_oe == 1'b0, "R1 oe after reset", 32'(sda_oe), 0);
    read_tx(8'h00, 4, "R1 reset value");

    wb[0] = 8'hA5; wb[1] = 8'h3C;
    write_tx(8'h10, 2, 1, "R3");
    read_tx(8'h10, 2, "R3 pair readback");

    for (int i = 0; i < 6; i++) wb[i] = 8'(8'h11 * (i + 1));
    write_tx(8'h20, 6, 1, "R4");
    read_tx(8'h20, 6, "R4 autoinc");

    wb[0] = 8'h99;
    write_tx(8'h32, 1, 1, "R5 stop");
    wb[0] = 8'h12; wb[1] = 8'h34; wb[2] = 8'h56;
    write_tx(8'h34, 3, 1, "R5 stop3");
    wb[0] = 8'h77;
    write_tx(8'h30, 1, 0, "R5 rs");
    read_tx(8'h30, 8, "R5 lone high");

    wb[0] = 8'hDE; wb[1] = 8'hC0; wb[2] = 8'hDE;
    write_tx(8'h41, 3, 1, "R6");
    read_tx(8'h40, 4, "R6 odd start");

    wb[0] = 8'hBE; wb[1] = 8'hEF; wb[2] = 8'h55; wb[3] = 8'h66;
    write_tx(8'h4E, 4, 1, "R7");
    read_tx(8'h4E, 4, "R7 past end");
    wb[0] = 8'h01; wb[1] = 8'h02;
    write_tx(8'h60, 2, 1, "R7 far");
    read_tx(8'h60, 2, "R7 far read");

    wb[0] = 8'hAA; wb[1] = 8'hBB; wb[2] = 8'hCC; wb[3] = 8'hDD;
    write_tx(8'h00, 4, 1, "R8");
    wb[0] = 8'h13; wb[1] = 8'h57;
    write_tx(8'h08, 2, 1, "R8 reg4");
    read_tx(8'h00, 4, "R8 ro reg1");
    read_tx(8'h08, 2, "R8 ro reg4");

    i2c_start();
    write_byte({7'h37, 1'b0}, a); check(!a, "R2 foreign addr nack", 32'(a), 0);
    write_byte(8'h10, a);         check(!a, "R2 silent after mismatch", 32'(a), 0);
    write_byte(8'h00, a);         check(!a, "R2 silent data", 32'(a), 0);
    write_byte(8'h00, a);
    check(sda_oe == 1'b0, "R2 released", 32'(sda_oe), 0);
    i2c_stop();
    read_tx(8'h10, 2, "R2 unchanged");

    wait (got_q.size() == 0);
    #(5 * CLK_PERIOD);
    check(oe_viol == 0, "R10 drive change with SCL high", 32'(oe_viol), 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule